// File: doc/BRIEF.md
# Two-Port Prioritized Memory Bank Switch

This block lets an I/O processor and a central processor share a set of memory banks over one bank-side bus. Each processor port presents a request, an 18-bit word address, a write flag and write data. It holds them until the switch returns a one-cycle grant with read data. The switch decodes the bank number from the address and raises that bank's request. It waits for the bank's grant and then returns the result to the port that owns the cycle. Only one memory cycle is in flight at a time. When both ports want the bus, the I/O port wins.

Address bit numbering counts from the most significant end. Bit 0 of the address is `addr[17]` and marks an illegal address. Bits 1 to 4 are `addr[16:13]` and give the bank number. Bits 5 to 17 are `addr[12:0]` and give the word offset inside the bank. An illegal address, or a bank number beyond the configured count, never reaches a bank. When `protect_en` is low, such a request simply waits for ever. When `protect_en` is high, the switch signals a trap on that port and otherwise drops the request.

Top module: `mem_port_switch`

## Requirements
- R1: A legal request that meets an idle switch and no competing request raises `bank_req[n]` in the next cycle, where n = `addr[16:13]`. During that cycle `bank_addr` equals `addr[12:0]`, and `bank_we`/`bank_wdata` carry the port's flag and data.
- R2: The cycle after the selected bank pulses its `bank_gnt`, the owning port sees its grant high for exactly one cycle. Its read data then equals the bank's read data from the `bank_gnt` cycle. A write returns the word's contents from before the write.
- R3: When both ports present legal requests in the same cycle to an idle switch, the I/O port's cycle is carried out and granted first. The central processor's cycle follows.
- R4: Once a bank request is raised, it and the bank-side address stay unchanged until that bank grants. A request that arrives meanwhile, even from the I/O port, waits until the current cycle completes.
- R5: A request with `addr[17]` = 1 while `protect_en` = 0 never receives a grant or a trap and never raises a bank request. The other port is still served while it waits.
- R6: A request whose bank number is equal to or above `NUM_BANKS` is handled exactly as an address with `addr[17]` set, both with and without protection.
- R7: With `protect_en` = 1, an illegal request raises the port's trap for exactly one cycle, in the cycle after the request is first seen. No bank request is raised. Holding the request does not trap again, but dropping and re-raising it does.
- R8: During and just after reset, all bank requests, port grants and traps are low.
- R9: At most one `bank_req` bit is high in any cycle, and the two port grants are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| protect_en | input | 1 | Trap illegal addresses instead of stalling |
| io_req | input | 1 | I/O port request, held until grant or trap |
| io_we | input | 1 | I/O port write flag |
| io_addr | input | 18 | I/O port word address |
| io_wdata | input | 18 | I/O port write data |
| io_gnt | output | 1 | I/O port one-cycle completion grant |
| io_rdata | output | 18 | Read data, valid with the grant |
| io_trap | output | 1 | I/O port illegal-address trap pulse |
| cpu_req | input | 1 | Central processor request |
| cpu_we | input | 1 | Central processor write flag |
| cpu_addr | input | 18 | Central processor word address |
| cpu_wdata | input | 18 | Central processor write data |
| cpu_gnt | output | 1 | Central processor completion grant |
| cpu_rdata | output | 18 | Read data, valid with the grant |
| cpu_trap | output | 1 | Central processor trap pulse |
| bank_req | output | NUM_BANKS | One request line per bank |
| bank_addr | output | 13 | Word offset broadcast to the banks |
| bank_we | output | 1 | Write flag broadcast to the banks |
| bank_wdata | output | 18 | Write data broadcast to the banks |
| bank_gnt | input | NUM_BANKS | Per-bank completion pulse |
| bank_rdata | input | NUM_BANKS*18 | Per-bank read data, bank n at bits n*18 upward |

## Verification
The hardest case to reach from the ports is a cycle that is already in flight when a higher-priority request arrives. The bench brings it about by starting a central processor access first. Two cycles later it raises an I/O request while the bank stub is still counting its latency. The scoreboard then expects the central processor's completion ahead of the I/O one. Two other cases need a port to be held deliberately in a state that never completes: a stalled illegal request, and a trapped request that is held and then re-raised. The bench does this with a timed hold task that counts grants, traps and bank requests. While one port is held stalled, the other port runs a normal access.

// File: rtl/mps_pkg.sv
// Shared definitions for the two-port memory bank switch.
// Assumes exactly two requesting ports: index 0 is the I/O port, which has
// fixed priority, and index 1 is the central processor port.
package mps_pkg;
    localparam int NUM_PORTS = 2;
    localparam int PORT_IO   = 0;
    localparam int PORT_CPU  = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } sw_state_t;
endpackage

// File: rtl/mps_addr_decode.sv
// Splits a word address into bank number and in-bank offset, and flags it
// legal when the sign bit is clear and the bank exists.
// Assumes the sign bit is the MSB and the bank field sits just below it.
module mps_addr_decode #(
    parameter int ADDR_W    = 18,
    parameter int SEL_W     = 4,
    parameter int NUM_BANKS = 4,
    localparam int OFF_W    = ADDR_W - 1 - SEL_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SEL_W-1:0]  bank_o,
    output logic [OFF_W-1:0]  off_o,
    output logic              legal_o
);
    // Field extraction and legality test
    always_comb begin
        bank_o  = addr_i[ADDR_W-2 -: SEL_W];
        off_o   = addr_i[OFF_W-1:0];
        legal_o = !addr_i[ADDR_W-1] && (32'(bank_o) < 32'(NUM_BANKS));
    end
endmodule

// File: rtl/mps_trap_ctl.sv
// Per-port trap generator: pulses the trap one cycle after an illegal request
// is first seen while protection is on, then stays quiet until the request
// is withdrawn. Assumes the requester holds req until it sees the trap.
module mps_trap_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic protect_en,
    input  logic req_i,
    input  logic legal_i,
    output logic trap_o
);
    logic held_q;
    logic fire;

    // A new illegal request under protection fires once
    always_comb fire = req_i && !legal_i && protect_en && !held_q;

    // Register the pulse and remember the request until it is dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_o <= 1'b0;
            held_q <= 1'b0;
        end else begin
            trap_o <= fire;
            held_q <= req_i && (held_q || fire);
        end
    end
endmodule

// File: rtl/mps_arbiter.sv
// Fixed-priority owner selection and cycle sequencing for the shared bank bus.
// IDLE picks an owner among legal requests (I/O first), BUSY waits for the
// owning bank's grant, DONE is the single cycle the port grant is shown.
// Assumes a granted requester drops its request during the DONE cycle.
module mps_arbiter
    import mps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] cand_i,
    input  logic                 hit_i,
    output sw_state_t            state_o,
    output logic                 owner_o,
    output logic                 start_o,
    output logic                 sel_o
);
    // Choose the winner among current candidates
    always_comb begin
        sel_o   = cand_i[PORT_IO] ? 1'b0 : 1'b1;
        start_o = (state_o == ST_IDLE) && (|cand_i);
    end

    // Sequence one memory cycle at a time; the owner is frozen until DONE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= ST_IDLE;
            owner_o <= 1'b0;
        end else begin
            unique case (state_o)
                ST_IDLE: if (start_o) begin
                    state_o <= ST_BUSY;
                    owner_o <= sel_o;
                end
                ST_BUSY: if (hit_i) state_o <= ST_DONE;
                ST_DONE: state_o <= ST_IDLE;
                default: state_o <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mem_port_switch.sv
// Two-port prioritized memory bank switch (top).
// Decodes each port's address, arbitrates with fixed I/O priority, drives one
// bank's request/grant handshake on a shared bank bus, and returns the result
// as a one-cycle grant. Illegal addresses stall, or trap under protection.
// Assumes banks hold bank_gnt for one cycle and keep inputs stable until then.
module mem_port_switch
    import mps_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 18,
    parameter int SEL_W     = 4,
    parameter int NUM_BANKS = 4,
    localparam int OFF_W    = ADDR_W - 1 - SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        protect_en,
    input  logic                        io_req,
    input  logic                        io_we,
    input  logic [ADDR_W-1:0]           io_addr,
    input  logic [DATA_W-1:0]           io_wdata,
    output logic                        io_gnt,
    output logic [DATA_W-1:0]           io_rdata,
    output logic                        io_trap,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic                        cpu_gnt,
    output logic [DATA_W-1:0]           cpu_rdata,
    output logic                        cpu_trap,
    output logic [NUM_BANKS-1:0]        bank_req,
    output logic [OFF_W-1:0]            bank_addr,
    output logic                        bank_we,
    output logic [DATA_W-1:0]           bank_wdata,
    input  logic [NUM_BANKS-1:0]        bank_gnt,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata
);
    logic [ADDR_W-1:0]    p_addr  [NUM_PORTS];
    logic [DATA_W-1:0]    p_wdata [NUM_PORTS];
    logic [NUM_PORTS-1:0] p_req;
    logic [NUM_PORTS-1:0] p_we;
    logic [SEL_W-1:0]     p_bank  [NUM_PORTS];
    logic [OFF_W-1:0]     p_off   [NUM_PORTS];
    logic [NUM_PORTS-1:0] p_legal;
    logic [NUM_PORTS-1:0] p_trap;
    logic [NUM_PORTS-1:0] cand;

    sw_state_t            state;
    logic                 owner;
    logic                 start;
    logic                 sel;
    logic                 bank_hit;
    logic [DATA_W-1:0]    hit_data;

    logic [SEL_W-1:0]     cur_bank;
    logic [OFF_W-1:0]     cur_off;
    logic                 cur_we;
    logic [DATA_W-1:0]    cur_wdata;
    logic [DATA_W-1:0]    rd_q;

    // Gather both ports into indexed arrays
    always_comb begin
        p_addr[PORT_IO]   = io_addr;
        p_addr[PORT_CPU]  = cpu_addr;
        p_wdata[PORT_IO]  = io_wdata;
        p_wdata[PORT_CPU] = cpu_wdata;
        p_req  = {cpu_req, io_req};
        p_we   = {cpu_we, io_we};
    end

    // One decoder and one trap controller per port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mps_addr_decode #(
            .ADDR_W    (ADDR_W),
            .SEL_W     (SEL_W),
            .NUM_BANKS (NUM_BANKS)
        ) u_dec (
            .addr_i  (p_addr[p]),
            .bank_o  (p_bank[p]),
            .off_o   (p_off[p]),
            .legal_o (p_legal[p])
        );

        mps_trap_ctl u_trap (
            .clk        (clk),
            .rst_n      (rst_n),
            .protect_en (protect_en),
            .req_i      (p_req[p]),
            .legal_i    (p_legal[p]),
            .trap_o     (p_trap[p])
        );
    end

    // Only legal requests compete for the bank bus
    always_comb cand = p_req & p_legal;

    mps_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand_i  (cand),
        .hit_i   (bank_hit),
        .state_o (state),
        .owner_o (owner),
        .start_o (start),
        .sel_o   (sel)
    );

    // Pick the current bank's grant and read data
    always_comb begin
        bank_hit = 1'b0;
        hit_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (cur_bank == SEL_W'(b)) begin
                bank_hit = bank_gnt[b];
                hit_data = bank_rdata[b*DATA_W +: DATA_W];
            end
        end
    end

    // Capture the winning cycle and the returned word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bank  <= '0;
            cur_off   <= '0;
            cur_we    <= 1'b0;
            cur_wdata <= '0;
            rd_q      <= '0;
        end else begin
            if (start) begin
                cur_bank  <= p_bank[sel];
                cur_off   <= p_off[sel];
                cur_we    <= p_we[sel];
                cur_wdata <= p_wdata[sel];
            end
            if ((state == ST_BUSY) && bank_hit) rd_q <= hit_data;
        end
    end

    // Per-bank request lanes
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
        assign bank_req[b] = (state == ST_BUSY) && (cur_bank == SEL_W'(b));
    end

    // Shared bank bus and port-side results
    always_comb begin
        bank_addr  = cur_off;
        bank_we    = cur_we;
        bank_wdata = cur_wdata;
        io_gnt     = (state == ST_DONE) && (owner == 1'b0);
        cpu_gnt    = (state == ST_DONE) && (owner == 1'b1);
        io_rdata   = rd_q;
        cpu_rdata  = rd_q;
        io_trap    = p_trap[PORT_IO];
        cpu_trap   = p_trap[PORT_CPU];
    end
endmodule

// File: rtl/mps_chk.sv
// Property checker for mem_port_switch, attached by bind below.
// Assumes requesters hold address stable while requesting.
module mps_chk #(
    parameter int ADDR_W    = 18,
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 protect_en,
    input logic                 io_req,
    input logic [ADDR_W-1:0]    io_addr,
    input logic                 cpu_req,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic                 io_gnt,
    input logic                 cpu_gnt,
    input logic                 io_trap,
    input logic                 cpu_trap,
    input logic [NUM_BANKS-1:0] bank_req,
    input logic [NUM_BANKS-1:0] bank_gnt
);
    // R9
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_req));

    // R9
    gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_gnt && cpu_gnt));

    // R2
    gnt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_gnt || cpu_gnt) |-> $past(|(bank_gnt & bank_req)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|bank_req) && !(|(bank_req & bank_gnt))) |=> $stable(bank_req));

    // R7
    io_trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_trap |=> !io_trap);

    // R7
    cpu_trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_trap |=> !cpu_trap);

    // R7
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_trap || cpu_trap) |-> $past(protect_en && (io_req || cpu_req)));

    // R5
    io_no_illegal_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_gnt |-> !io_addr[ADDR_W-1]);

    // R5
    cpu_no_illegal_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |-> !cpu_addr[ADDR_W-1]);
endmodule

bind mem_port_switch mps_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .protect_en (protect_en),
    .io_req     (io_req),
    .io_addr    (io_addr),
    .cpu_req    (cpu_req),
    .cpu_addr   (cpu_addr),
    .io_gnt     (io_gnt),
    .cpu_gnt    (cpu_gnt),
    .io_trap    (io_trap),
    .cpu_trap   (cpu_trap),
    .bank_req   (bank_req),
    .bank_gnt   (bank_gnt)
);

// File: tb/tb_mem_port_switch.sv
`timescale 1ns/1ps
module tb_mem_port_switch;
    localparam int AW  = 18;
    localparam int DW  = 18;
    localparam int NB  = 4;
    localparam int OW  = 13;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic protect_en = 1'b0;
    logic io_req = 1'b0, io_we = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] io_addr = '0, cpu_addr = '0;
    logic [DW-1:0] io_wdata = '0, cpu_wdata = '0;
    logic io_gnt, cpu_gnt, io_trap, cpu_trap, bank_we;
    logic [DW-1:0] io_rdata, cpu_rdata, bank_wdata;
    logic [NB-1:0] bank_req;
    logic [NB-1:0] bank_gnt;
    logic [OW-1:0] bank_addr;
    logic [NB*DW-1:0] bank_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mem_port_switch dut (
        .clk(clk), .rst_n(rst_n), .protect_en(protect_en),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_gnt(io_gnt), .io_rdata(io_rdata), .io_trap(io_trap),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_gnt(cpu_gnt), .cpu_rdata(cpu_rdata), .cpu_trap(cpu_trap),
        .bank_req(bank_req), .bank_addr(bank_addr), .bank_we(bank_we),
        .bank_wdata(bank_wdata), .bank_gnt(bank_gnt), .bank_rdata(bank_rdata)
    );

    // Bank stubs: fixed latency, small word store
    logic [DW-1:0] smem  [NB][64];
    logic [DW-1:0] model [NB][64];
    int scnt [NB];

    initial begin
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < 64; i++) begin
                smem[b][i]  = DW'(b * 4096 + i * 7 + 1);
                model[b][i] = DW'(b * 4096 + i * 7 + 1);
            end
    end

    always_comb
        for (int b = 0; b < NB; b++)
            bank_rdata[b*DW +: DW] = smem[b][bank_addr[5:0]];

    always @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (!rst_n) begin
                bank_gnt[b] <= 1'b0;
                scnt[b]     <= 0;
            end else if (bank_gnt[b]) begin
                bank_gnt[b] <= 1'b0;
                scnt[b]     <= 0;
                if (bank_we) smem[b][bank_addr[5:0]] <= bank_wdata;
            end else if (bank_req[b]) begin
                if (scnt[b] == LAT - 1) bank_gnt[b] <= 1'b1;
                else scnt[b] <= scnt[b] + 1;
            end
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int bank, input int off, input bit neg);
        return {neg, 4'(bank), 13'(off)};
    endfunction

    // Scoreboard
    typedef struct packed {
        logic          port;
        logic [3:0]    bank;
        logic [DW-1:0] data;
    } exp_t;
    exp_t sb[$];
    int last_bank = -1;

    task automatic push_exp(input bit port, input int bank, input int off,
                            input bit we, input logic [DW-1:0] wd);
        exp_t e;
        e.port = port;
        e.bank = 4'(bank);
        e.data = model[bank][off];
        sb.push_back(e);
        if (we) model[bank][off] = wd;
    endtask

    // Monitor: pops expected completions as grants appear (R2, R3, R4, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int b = 0; b < NB; b++) if (bank_req[b]) last_bank = b;
            if (io_gnt && cpu_gnt) check(1'b0, "R9", 2, 1);
            else if (io_gnt || cpu_gnt) begin
                if (sb.size() == 0) check(1'b0, "R2", 1, 0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.port == cpu_gnt, "R3/R4 grant order", int'(cpu_gnt), int'(e.port));
                    check(last_bank == int'(e.bank), "R1 bank decode", last_bank, int'(e.bank));
                    check((cpu_gnt ? cpu_rdata : io_rdata) == e.data, "R2 read data",
                          int'(cpu_gnt ? cpu_rdata : io_rdata), int'(e.data));
                end
            end
        end
    end

    // Driver: complete one access on a port
    task automatic drive(input bit port, input int bank, input int off,
                         input bit we, input logic [DW-1:0] wd, input bit fast);
        @(negedge clk);
        if (port) begin
            cpu_addr = mk(bank, off, 1'b0); cpu_we = we; cpu_wdata = wd; cpu_req = 1'b1;
        end else begin
            io_addr = mk(bank, off, 1'b0); io_we = we; io_wdata = wd; io_req = 1'b1;
        end
        @(negedge clk);
        if (fast) begin
            check(bank_req == NB'(1 << bank), "R1 immediate bank request", int'(bank_req), 1 << bank);
            check(bank_addr == OW'(off), "R1 offset", int'(bank_addr), off);
            check(bank_we == we && (!we || bank_wdata == wd), "R1 write flag/data", int'(bank_we), int'(we));
        end
        while (!(port ? cpu_gnt : io_gnt)) @(negedge clk);
        if (port) cpu_req = 1'b0; else io_req = 1'b0;
    endtask

    // Hold an illegal request for n cycles, counting what it produces
    task automatic hold_bad(input bit port, input logic [AW-1:0] a, input int n,
                            output int gnts, output int traps, output int first_trap,
                            output int breqs);
        gnts = 0; traps = 0; first_trap = -1; breqs = 0;
        @(negedge clk);
        if (port) begin cpu_addr = a; cpu_we = 1'b0; cpu_req = 1'b1; end
        else      begin io_addr = a;  io_we = 1'b0;  io_req = 1'b1;  end
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (port ? cpu_gnt : io_gnt) gnts++;
            if (port ? cpu_trap : io_trap) begin
                traps++;
                if (first_trap < 0) first_trap = i;
            end
            if (|bank_req) breqs++;
        end
        if (port) cpu_req = 1'b0; else io_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int g, t, ft, br;
        repeat (4) @(negedge clk);
        // R8: reset state
        check(bank_req == '0 && !io_gnt && !cpu_gnt, "R8 during reset", int'(bank_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!io_trap && !cpu_trap && bank_req == '0, "R8 after reset", int'(io_trap), 0);

        // R1/R2: uncontended accesses on both ports and several banks
        push_exp(0, 0, 5, 1, 18'h2aaaa);  drive(0, 0, 5, 1, 18'h2aaaa, 1);
        push_exp(1, 0, 5, 0, '0);         drive(1, 0, 5, 0, '0, 1);
        push_exp(1, 3, 63, 1, 18'h15555); drive(1, 3, 63, 1, 18'h15555, 1);
        push_exp(0, 3, 63, 0, '0);        drive(0, 3, 63, 0, '0, 1);
        push_exp(0, 2, 17, 0, '0);        drive(0, 2, 17, 0, '0, 1);

        // R3: simultaneous requests, I/O first
        push_exp(0, 1, 1, 0, '0);
        push_exp(1, 2, 2, 0, '0);
        fork
            drive(0, 1, 1, 0, '0, 0);
            drive(1, 2, 2, 0, '0, 0);
        join
        push_exp(0, 1, 9, 1, 18'h00777);
        push_exp(1, 1, 9, 0, '0);
        fork
            drive(0, 1, 9, 1, 18'h00777, 0);
            drive(1, 1, 9, 0, '0, 0);
        join

        // R4: cycle in flight keeps its owner
        push_exp(1, 2, 30, 0, '0);
        push_exp(0, 3, 31, 0, '0);
        fork
            drive(1, 2, 30, 0, '0, 1);
            begin repeat (2) @(negedge clk); drive(0, 3, 31, 0, '0, 0); end
        join

        // R5: sign-bit address stalls, other port still served
        push_exp(1, 0, 12, 0, '0);
        fork
            begin
                hold_bad(0, mk(0, 3, 1'b1), 30, g, t, ft, br);
                check(g == 0, "R5 no grant", g, 0);
                check(t == 0, "R5 no trap", t, 0);
            end
            begin repeat (5) @(negedge clk); drive(1, 0, 12, 0, '0, 0); end
        join
        // R5 alone: no bank request at all
        hold_bad(0, mk(1, 4, 1'b1), 15, g, t, ft, br);
        check(br == 0 && g == 0, "R5 no bank request", br, 0);

        // R6: bank number beyond NUM_BANKS stalls like an illegal address
        hold_bad(1, mk(5, 0, 1'b0), 20, g, t, ft, br);
        check(g == 0 && t == 0 && br == 0, "R6 unpopulated bank stalls", g + t + br, 0);

        // R7: protection traps
        @(negedge clk); protect_en = 1'b1;
        hold_bad(0, mk(0, 0, 1'b1), 10, g, t, ft, br);
        check(t == 1, "R7 single trap pulse", t, 1);
        check(ft == 1, "R7 trap timing", ft, 1);
        check(g == 0 && br == 0, "R7 no memory cycle", g + br, 0);
        hold_bad(0, mk(0, 0, 1'b1), 6, g, t, ft, br);
        check(t == 1 && ft == 1, "R7 re-raised request traps again", t, 1);
        // R6 under protection
        hold_bad(1, mk(9, 1, 1'b0), 6, g, t, ft, br);
        check(t == 1 && g == 0 && br == 0, "R6 unpopulated bank traps", t, 1);
        // legal traffic after traps
        push_exp(1, 2, 40, 0, '0); drive(1, 2, 40, 0, '0, 1);
        @(negedge clk); protect_en = 1'b0;

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2 all completions seen", sb.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule